// File: doc/BRIEF.md
# Per-Element Vector Bit-Manipulation Unit

This block applies one bit-manipulation operation to every element of a packed slice of a vector register and delivers the result one cycle later. The element width is chosen per request as 8, 16, 32 or 64 bits. The operations are:

- and-with-inverted-operand
- reversal of all bits of an element
- reversal of the bits inside each byte
- set-bit count per element
- trailing-zero and leading-zero counts
- widening logical left shift, which produces elements of twice the width

Every path through the datapath is a fixed combinational network that feeds a single output register. The time from acceptance to result never depends on operand values.

A request enters on a valid/ready handshake. It is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty, or is being drained in the same cycle. The result then waits in the output register, with `out_valid` high, until a cycle where `out_ready` is high. While `out_ready` is low, the result and `out_valid` hold, and `in_ready` stays low, so no request is lost or overwritten. The second operand is either the vector slice `in_src_b` or, when `in_use_scalar` is set, the low element-width bits of `in_scalar` repeated for every element. `SLICE_W` must be a multiple of 64.

Top module: `vbm_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Operation code 0 (and-not) gives, per bit, `in_src_a AND NOT second-operand`. The second operand is the one taken from `in_src_b` or the scalar.
- R3: Operation code 1 reverses the bit order across each whole element, at the selected width (width code 0=8, 1=16, 2=32, 3=64 bits).
- R4: Operation code 2 reverses the bits within every byte of each element and keeps the byte order, for every width.
- R5: Operation code 3 returns, in each element, the number of set bits of that element alone.
- R6: Operation code 4 returns the trailing-zero count of each element. An all-zero element returns the element width.
- R7: Operation code 5 returns the leading-zero count of each element. An all-zero element returns the element width.
- R8: Operation code 6 zero-extends each element to twice its width and shifts it left by the low log2(2×width) bits of the second-operand element. Element e lands at bits [2×width×e +: 2×width] of `out_data`.
- R9: For every operation other than 6, element e lands at bits [width×e +: width] and the upper half of `out_data` is zero. Operation code 7 gives an all-zero result.
- R10: A request accepted on an edge raises `out_valid` on that edge, one cycle after acceptance for every operand value.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold and `in_ready` is low.
- R12: When `in_use_scalar` is 1, every element uses the low width bits of `in_scalar` as its second operand, and `in_src_b` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 3 | Operation code |
| in_sew | input | 2 | Element width code |
| in_use_scalar | input | 1 | Take the second operand from the scalar |
| in_src_a | input | SLICE_W | First operand slice |
| in_src_b | input | SLICE_W | Second operand slice (inverted operand, or shift amounts) |
| in_scalar | input | 64 | Scalar or immediate second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 2*SLICE_W | Result slice |

## Verification
The handshake assertions assume that the consumer's `out_ready` is a clean 0 or 1 while reset is released. They also assume that operation and width codes are sampled only on an accepting edge. The bench changes its inputs only on falling edges and drops `in_valid` after each accepted request, so every accept edge carries exactly one intended request. The stall test holds `out_ready` low across several edges, while a second request is offered, before it releases the result.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
  typedef enum logic [2:0] {
    OP_ANDN  = 3'd0,
    OP_BREV  = 3'd1,
    OP_BREV8 = 3'd2,
    OP_CPOP  = 3'd3,
    OP_CTZ   = 3'd4,
    OP_CLZ   = 3'd5,
    OP_WSLL  = 3'd6,
    OP_RSVD  = 3'd7
  } vbm_op_e;

  typedef enum logic [1:0] {
    SEW_8  = 2'd0,
    SEW_16 = 2'd1,
    SEW_32 = 2'd2,
    SEW_64 = 2'd3
  } vbm_sew_e;

  localparam int NUM_SEW = 4;
  localparam int MAX_EW  = 64;
endpackage

// File: rtl/vbm_elem.sv
module vbm_elem
  import vbm_pkg::*;
#(
  parameter int EW = 8
) (
  input  logic [2:0]      op,
  input  logic [EW-1:0]   a,
  input  logic [EW-1:0]   b,
  output logic [2*EW-1:0] res
);
  localparam int CW  = $clog2(EW + 1);
  localparam int SHW = $clog2(2 * EW);

  logic [EW-1:0]   rev_all;
  logic [EW-1:0]   rev_byte;
  logic [CW-1:0]   pop;
  logic [CW-1:0]   tz;
  logic [CW-1:0]   lz;
  logic [2*EW-1:0] shl;

  // full reversal and in-byte reversal: pure wiring
  always_comb begin
    for (int i = 0; i < EW; i++) begin
      rev_all[i]  = a[EW-1-i];
      rev_byte[i] = a[(i/8)*8 + 7 - (i%8)];
    end
  end

  // counts: fixed-depth networks, no early exit
  always_comb begin
    pop = '0;
    for (int i = 0; i < EW; i++) pop = pop + CW'(a[i]);
  end

  always_comb begin
    tz = CW'(EW);
    for (int i = EW - 1; i >= 0; i--) if (a[i]) tz = CW'(i);
  end

  always_comb begin
    lz = CW'(EW);
    for (int i = 0; i < EW; i++) if (a[i]) lz = CW'(EW - 1 - i);
  end

  assign shl = {{EW{1'b0}}, a} << b[SHW-1:0];

  always_comb begin
    case (vbm_op_e'(op))
      OP_ANDN:  res = {{EW{1'b0}}, a & ~b};
      OP_BREV:  res = {{EW{1'b0}}, rev_all};
      OP_BREV8: res = {{EW{1'b0}}, rev_byte};
      OP_CPOP:  res = {{(2*EW-CW){1'b0}}, pop};
      OP_CTZ:   res = {{(2*EW-CW){1'b0}}, tz};
      OP_CLZ:   res = {{(2*EW-CW){1'b0}}, lz};
      OP_WSLL:  res = shl;
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/vbm_group.sv
module vbm_group
  import vbm_pkg::*;
#(
  parameter int EW      = 8,
  parameter int SLICE_W = 64
) (
  input  logic [2:0]           op,
  input  logic                 use_scalar,
  input  logic [SLICE_W-1:0]   src_a,
  input  logic [SLICE_W-1:0]   src_b,
  input  logic [EW-1:0]        scalar,
  output logic [2*SLICE_W-1:0] res
);
  localparam int NE = SLICE_W / EW;

  logic [2*SLICE_W-1:0] wide_v;
  logic [SLICE_W-1:0]   narrow_v;

  for (genvar e = 0; e < NE; e++) begin : g_el
    logic [EW-1:0]   b_el;
    logic [2*EW-1:0] r_el;

    assign b_el = use_scalar ? scalar : src_b[e*EW +: EW];

    vbm_elem #(.EW(EW)) u_elem (
      .op  (op),
      .a   (src_a[e*EW +: EW]),
      .b   (b_el),
      .res (r_el)
    );

    assign wide_v[e*2*EW +: 2*EW] = r_el;
    assign narrow_v[e*EW +: EW]   = r_el[EW-1:0];
  end

  assign res = (vbm_op_e'(op) == OP_WSLL) ? wide_v : {{SLICE_W{1'b0}}, narrow_v};
endmodule

// File: rtl/vbm_unit.sv
module vbm_unit
  import vbm_pkg::*;
#(
  parameter int SLICE_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2:0]           in_op,
  input  logic [1:0]           in_sew,
  input  logic                 in_use_scalar,
  input  logic [SLICE_W-1:0]   in_src_a,
  input  logic [SLICE_W-1:0]   in_src_b,
  input  logic [MAX_EW-1:0]    in_scalar,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2*SLICE_W-1:0] out_data
);
  localparam int OUT_W = 2 * SLICE_W;

  logic [OUT_W-1:0] grp_res [NUM_SEW];
  logic [OUT_W-1:0] sel_res;
  logic             accept;
  logic             vld_q;
  logic [OUT_W-1:0] data_q;
  logic [2:0]       op_q;
  logic [1:0]       sew_q;

  for (genvar k = 0; k < NUM_SEW; k++) begin : g_sew
    localparam int EW = 8 << k;
    vbm_group #(.EW(EW), .SLICE_W(SLICE_W)) u_grp (
      .op         (in_op),
      .use_scalar (in_use_scalar),
      .src_a      (in_src_a),
      .src_b      (in_src_b),
      .scalar     (in_scalar[EW-1:0]),
      .res        (grp_res[k])
    );
  end

  assign sel_res  = grp_res[in_sew];
  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      op_q   <= '0;
      sew_q  <= '0;
    end else begin
      if (accept) begin
        vld_q  <= 1'b1;
        data_q <= sel_res;
        op_q   <= in_op;
        sew_q  <= in_sew;
      end else if (out_ready) begin
        vld_q  <= 1'b0;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;

  // R10: fixed one-cycle latency from acceptance
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R11: stalled result is held
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R11: no acceptance while a stalled result is pending
  a_r11_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: non-widening results keep the upper half clear
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q != OP_WSLL) |-> (out_data[OUT_W-1:SLICE_W] == '0));

  // R5: a 64-bit count never exceeds the element width
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sew_q == SEW_64 && (op_q == OP_CPOP || op_q == OP_CTZ || op_q == OP_CLZ))
      |-> (out_data[63:0] <= 64'd64));
endmodule

// File: tb/vbm_unit_bench.sv
module vbm_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 64;
  localparam int NT = 12;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          in_valid = 0;
  logic          in_ready;
  logic [2:0]    in_op = 0;
  logic [1:0]    in_sew = 0;
  logic          in_use_scalar = 0;
  logic [SW-1:0] in_src_a = 0;
  logic [SW-1:0] in_src_b = 0;
  logic [63:0]   in_scalar = 0;
  logic          out_valid;
  logic          out_ready = 1;
  logic [2*SW-1:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbm_unit #(.SLICE_W(SW)) u_vbm_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_sew(in_sew), .in_use_scalar(in_use_scalar),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_scalar(in_scalar),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // stimulus table: op, sew, scalar flag, a, b, scalar
  localparam logic [2:0]  T_OP [NT] = '{3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd3,
                                        3'd3, 3'd4, 3'd5, 3'd6, 3'd6, 3'd4};
  localparam logic [1:0]  T_SEW[NT] = '{2'd0, 2'd3, 2'd1, 2'd3, 2'd2, 2'd0,
                                        2'd2, 2'd1, 2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic        T_US [NT] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
                                        1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [63:0] T_A  [NT] = '{64'hF0F0_1234_ABCD_00FF, 64'hDEAD_BEEF_0123_4567,
                                        64'h8001_1234_0F0F_C3A5, 64'h0000_0000_0000_0003,
                                        64'h0123_4567_89AB_CDEF, 64'hFF00_7F01_8081_5AA5,
                                        64'hFFFF_FFFF_0000_0001, 64'h0000_8000_0100_0030,
                                        64'h0001_0280_40FF_0010, 64'h8001_00FF_1234_0001,
                                        64'hF000_000F_0000_0001, 64'h8000_0000_0000_0000};
  localparam logic [63:0] T_B  [NT] = '{64'h0F0F_FFFF_5555_F00F, 64'hFFFF_FFFF_FFFF_FFFF,
                                        64'h0,                   64'h0,
                                        64'h0,                   64'h0,
                                        64'h0,                   64'h0,
                                        64'h0,                   64'hFFFF_FFFF_FFFF_FFFF,
                                        64'h0000_0003_0000_001F, 64'h0};
  localparam logic [63:0] T_SC [NT] = '{64'h0, 64'h00FF_00FF_00FF_00FF, 64'h0, 64'h0,
                                        64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
                                        64'h0000_0000_0000_0014, 64'h0, 64'h0};

  // reference model written from the requirements
  function automatic logic [127:0] model(input logic [2:0] op, input logic [1:0] sew,
                                         input logic us, input logic [63:0] a,
                                         input logic [63:0] b, input logic [63:0] sc);
    int ew = 8 << sew;
    int ne = 64 / ew;
    logic [127:0] r = '0;
    logic [63:0] mask = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
    for (int e = 0; e < ne; e++) begin
      logic [63:0] ea = (a >> (e * ew)) & mask;
      logic [63:0] eb = us ? (sc & mask) : ((b >> (e * ew)) & mask);
      logic [63:0] v = '0;
      int cnt = 0;
      bit seen = 0;
      case (op)
        3'd0: v = ea & ~eb & mask;
        3'd1: for (int i = 0; i < ew; i++) v[i] = ea[ew-1-i];
        3'd2: for (int i = 0; i < ew; i++) v[i] = ea[(i/8)*8 + 7 - (i%8)];
        3'd3: begin for (int i = 0; i < ew; i++) cnt += int'(ea[i]); v = 64'(cnt); end
        3'd4: begin
          for (int i = 0; i < ew; i++) if (!seen) begin if (ea[i]) seen = 1; else cnt++; end
          v = 64'(cnt);
        end
        3'd5: begin
          for (int i = ew - 1; i >= 0; i--) if (!seen) begin if (ea[i]) seen = 1; else cnt++; end
          v = 64'(cnt);
        end
        default: v = '0;
      endcase
      if (op == 3'd6) begin
        int sh = int'(eb % 64'(2 * ew));
        logic [127:0] w = 128'(ea) << sh;
        if (ew < 64) w = w & ((128'd1 << (2 * ew)) - 128'd1);
        r = r | (w << (e * 2 * ew));
      end else begin
        r = r | (128'(v) << (e * ew));
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive at falling edge, result visible one edge later
  task automatic run(input logic [2:0] op, input logic [1:0] sew, input logic us,
                     input logic [63:0] a, input logic [63:0] b, input logic [63:0] sc);
    @(negedge clk);
    in_op = op; in_sew = sew; in_use_scalar = us;
    in_src_a = a; in_src_b = b; in_scalar = sc; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R10 valid after one cycle", {127'd0, out_valid}, 128'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {127'd0, out_valid}, 128'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 out_valid after reset", {127'd0, out_valid}, 128'd0);
    chk("R1 in_ready after reset", {127'd0, in_ready}, 128'd1);

    // table walk (R2..R9, R12)
    for (int t = 0; t < NT; t++) begin
      run(T_OP[t], T_SEW[t], T_US[t], T_A[t], T_B[t], T_SC[t]);
      chk($sformatf("R2-R9 table entry %0d op %0d (R12 when scalar)", t, T_OP[t]),
          out_data, model(T_OP[t], T_SEW[t], T_US[t], T_A[t], T_B[t], T_SC[t]));
    end

    // directed corner cases with literal expectations
    run(3'd4, 2'd0, 0, 64'h0, 64'h0, 64'h0);
    chk("R6 ctz all-zero bytes", out_data, 128'h0808_0808_0808_0808);
    run(3'd5, 2'd3, 0, 64'h1, 64'h0, 64'h0);
    chk("R7 clz of one", out_data, 128'h3F);
    run(3'd5, 2'd1, 0, 64'h0, 64'h0, 64'h0);
    chk("R7 clz all-zero halfwords", out_data, 128'h0010_0010_0010_0010);
    run(3'd8 - 3'd5, 2'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0);
    chk("R5 cpop full 64-bit", out_data, 128'h40);
    run(3'd6, 2'd0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h9);
    chk("R8 wsll amount truncated", out_data, 128'hFE00_FE00_FE00_FE00_FE00_FE00_FE00_FE00);
    run(3'd6, 2'd3, 1, 64'h1, 64'h0, 64'h7F);
    chk("R8 wsll to top bit", out_data, {1'b1, 127'd0});
    run(3'd2, 2'd2, 0, 64'h0102_0304_8040_2010, 64'h0, 64'h0);
    chk("R4 brev8 byte order kept", out_data, 128'h8040_C020_0102_0408);
    run(3'd1, 2'd1, 0, 64'h0001_0001_0001_0001, 64'h0, 64'h0);
    chk("R3 brev halfword", out_data, 128'h8000_8000_8000_8000);
    run(3'd0, 2'd1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h00FF_00FF_00FF_00FF, 64'h0);
    chk("R2 andn inverts second", out_data, 128'hFF00_FF00_FF00_FF00);
    run(3'd0, 2'd0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0F);
    chk("R12 scalar replaces src_b", out_data, 128'hF0F0_F0F0_F0F0_F0F0);
    run(3'd7, 2'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0);
    chk("R9 reserved op zero", out_data, 128'h0);

    // back-pressure (R11)
    @(negedge clk);
    out_ready = 0;
    in_op = 3'd3; in_sew = 2'd0; in_use_scalar = 0;
    in_src_a = 64'h0103_0307_0F1F_3F7F; in_src_b = 0; in_valid = 1;
    @(negedge clk);
    in_src_a = 64'hFFFF_FFFF_FFFF_FFFF; in_op = 3'd1;
    chk("R11 in_ready low when stalled", {127'd0, in_ready}, 128'd0);
    repeat (3) @(negedge clk);
    chk("R11 valid held", {127'd0, out_valid}, 128'd1);
    chk("R11 data held", out_data, 128'h0102_0203_0405_0607);
    in_valid = 0;
    out_ready = 1;
    @(negedge clk);
    chk("R11 drained", {127'd0, out_valid}, 128'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule